// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. After a synchronous reset it steps through the start-up procedure the memory needs before it can take any traffic. It first holds the command bus at NOP while the clock settles. It then closes every bank with a precharge-all and runs two auto-refresh cycles. Finally it writes the mode register and waits out the load delay. Only then does it raise `ready`, which tells the downstream controller that it may take over the pins.

All timing is set at elaboration. The settle window is the product of the clock frequency in MHz and a microsecond count. The command-to-command spacings after precharge, refresh and mode load are given in clock cycles. The mode word is built from parameter fields: burst length code, burst ordering, CAS latency code and write-burst mode. A word with an unsupported latency or burst code is never written to the device. The sequencer raises `cfg_err` and parks instead.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high and for exactly CLK_MHZ*STABLE_US cycles after it falls, the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 4'b0111. `addr` and `ba` are zero during that window.
- R2: The next cycle carries a single PRECHARGE (4'b0010) with addr[10]=1 and every other address and bank bit 0.
- R3: The first AUTO REFRESH (4'b0001) follows after max(T_RP_CYC-1,1) NOP cycles.
- R4: Exactly two AUTO REFRESH commands are issued. Each is followed by max(T_RFC_CYC-1,1) NOP cycles.
- R5: After the second refresh gap, LOAD MODE (4'b0000) is issued once with ba=0. Its address is zero-filled above bit 9 and laid out as: bit 9 write-single flag, bits 8:7 = 00, bits 6:4 CAS latency code, bit 3 interleave flag, bits 2:0 burst length code.
- R6: `ready` is 0 until max(T_MRD_CYC-1,1) NOP cycles after LOAD MODE have passed. It then stays 1, and the pins stay at NOP.
- R7: `cke` is 1 in every cycle, reset included.
- R8: The mode word is legal when both of these hold. The CAS code is 2 or 3. The burst code is 0..3, or 7 with sequential ordering (interleave flag 0). For an illegal word, `cfg_err` is 1 from the first cycle after reset, LOAD MODE is never issued, `ready` stays 0 and the pins stay at NOP after the refreshes. For a legal word, `cfg_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus, carries A10 and the mode word |
| ready | output | 1 | Initialization complete |
| cfg_err | output | 1 | Parameterized mode word is illegal |

## Verification
The hardest case to reach is the legality decision. It is fixed at elaboration, so no input can steer one instance through both the legal and the illegal branch. The bench therefore instantiates one copy of the sequencer for each of the 128 combinations of burst code, ordering and CAS code, all with minimum spacings. It checks every copy at the cycle where LOAD MODE is due, and checks `ready`/`cfg_err` once the load delay has passed. A separate instance with wider spacings is compared cycle by cycle against a timeline computed from its parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [3:0] {
        PH_STABLE,
        PH_PRECHG,
        PH_GAP_RP,
        PH_REFRESH,
        PH_GAP_RFC,
        PH_LOADMODE,
        PH_GAP_MRD,
        PH_READY,
        PH_HALT
    } phase_e;

    typedef struct packed {
        logic       wr_single;
        logic [1:0] op_mode;
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] burst_len;
    } mode_word_t;

    localparam int MODE_W        = $bits(mode_word_t);
    localparam int REFRESH_COUNT = 2;
    localparam int PRECHG_BIT    = 10;

    // NOP cycles placed after a command so that the next one lands no
    // earlier than the requested spacing; never less than one.
    function automatic int gap_cycles(input int spacing);
        return (spacing > 1) ? spacing - 1 : 1;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic mode_legal(input mode_word_t m);
        logic cl_ok;
        logic bl_ok;
        cl_ok = (m.cas_lat == 3'd2) || (m.cas_lat == 3'd3);
        bl_ok = (m.burst_len <= 3'd3) || ((m.burst_len == 3'd7) && !m.interleave);
        return cl_ok && bl_ok && (m.op_mode == 2'b00);
    endfunction

endpackage

// File: rtl/sinit_mode_check.sv
module sinit_mode_check
    import sdram_init_pkg::*;
#(
    parameter logic [2:0] BL_CODE           = 3'd3,
    parameter logic       BURST_INTERLEAVED = 1'b0,
    parameter logic [2:0] CL_CODE           = 3'd3,
    parameter logic       WRITE_SINGLE      = 1'b0
) (
    output logic              mode_ok,
    output logic [MODE_W-1:0] mode_bits
);
    mode_word_t word;

    always_comb begin
        word.wr_single  = WRITE_SINGLE;
        word.op_mode    = 2'b00;
        word.cas_lat    = CL_CODE;
        word.interleave = BURST_INTERLEAVED;
        word.burst_len  = BL_CODE;
    end

    assign mode_ok   = mode_legal(word);
    assign mode_bits = word;
endmodule

// File: rtl/sinit_phase_timer.sv
module sinit_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == limit);
endmodule

// File: rtl/sinit_pin_drive.sv
module sinit_pin_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  phase_e            phase,
    input  logic [MODE_W-1:0] mode_bits,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    cmd_e cmd;

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        case (phase)
            PH_PRECHG: begin
                cmd              = CMD_PRE;
                addr[PRECHG_BIT] = 1'b1;
            end
            PH_REFRESH:  cmd = CMD_REF;
            PH_LOADMODE: begin
                cmd  = CMD_LMR;
                addr = {{(ADDR_W-MODE_W){1'b0}}, mode_bits};
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign ba    = '0;
    assign ready = (phase == PH_READY);
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int         ADDR_W            = 13,
    parameter int         BANK_W            = 2,
    parameter int         CLK_MHZ           = 100,
    parameter int         STABLE_US         = 100,
    parameter int         T_RP_CYC          = 3,
    parameter int         T_RFC_CYC         = 9,
    parameter int         T_MRD_CYC         = 2,
    parameter logic [2:0] BL_CODE           = 3'd3,
    parameter logic       BURST_INTERLEAVED = 1'b0,
    parameter logic [2:0] CL_CODE           = 3'd3,
    parameter logic       WRITE_SINGLE      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              cfg_err
);
    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int GAP_RP     = gap_cycles(T_RP_CYC);
    localparam int GAP_RFC    = gap_cycles(T_RFC_CYC);
    localparam int GAP_MRD    = gap_cycles(T_MRD_CYC);
    localparam int LONGEST    = max_of(max_of(STABLE_CYC, GAP_RP), max_of(GAP_RFC, GAP_MRD));
    localparam int CNT_W      = $clog2(LONGEST + 1);
    localparam int REF_W      = $clog2(REFRESH_COUNT + 1);

    phase_e            phase_q, phase_d;
    logic [REF_W-1:0]  refs_q;
    logic [CNT_W-1:0]  limit;
    logic              tmr_clear;
    logic              tmr_done;
    logic              mode_ok;
    logic [MODE_W-1:0] mode_bits;

    sinit_mode_check #(
        .BL_CODE(BL_CODE),
        .BURST_INTERLEAVED(BURST_INTERLEAVED),
        .CL_CODE(CL_CODE),
        .WRITE_SINGLE(WRITE_SINGLE)
    ) mode_i (
        .mode_ok(mode_ok),
        .mode_bits(mode_bits)
    );

    sinit_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk),
        .rst(rst),
        .clear(tmr_clear),
        .limit(limit),
        .expired(tmr_done)
    );

    always_comb begin
        phase_d = phase_q;
        limit   = '0;
        case (phase_q)
            PH_STABLE: begin
                limit = CNT_W'(STABLE_CYC - 1);
                if (tmr_done) phase_d = PH_PRECHG;
            end
            PH_PRECHG:  phase_d = PH_GAP_RP;
            PH_GAP_RP: begin
                limit = CNT_W'(GAP_RP - 1);
                if (tmr_done) phase_d = PH_REFRESH;
            end
            PH_REFRESH: phase_d = PH_GAP_RFC;
            PH_GAP_RFC: begin
                limit = CNT_W'(GAP_RFC - 1);
                if (tmr_done) begin
                    if (refs_q == REF_W'(REFRESH_COUNT))
                        phase_d = mode_ok ? PH_LOADMODE : PH_HALT;
                    else
                        phase_d = PH_REFRESH;
                end
            end
            PH_LOADMODE: phase_d = PH_GAP_MRD;
            PH_GAP_MRD: begin
                limit = CNT_W'(GAP_MRD - 1);
                if (tmr_done) phase_d = PH_READY;
            end
            default: phase_d = phase_q;
        endcase
    end

    assign tmr_clear = (phase_d != phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_STABLE;
            refs_q  <= '0;
            cfg_err <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cfg_err <= !mode_ok;
            if (phase_q == PH_REFRESH) refs_q <= refs_q + 1'b1;
        end
    end

    sinit_pin_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) pins_i (
        .phase(phase_q),
        .mode_bits(mode_bits),
        .cs_n(cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n(we_n),
        .ba(ba),
        .addr(addr),
        .ready(ready)
    );

    assign cke = 1'b1;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int ADDR_W     = 13,
    parameter int BANK_W     = 2,
    parameter int STABLE_CYC = 100
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ADDR_W-1:0] addr,
    input logic              ready,
    input logic              cfg_err
);
    logic [3:0] pins;
    logic       pre_seen;
    logic [1:0] ref_seen;
    int         settle_cnt;

    assign pins = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_seen   <= 1'b0;
            ref_seen   <= 2'd0;
            settle_cnt <= 0;
        end else begin
            if (pins == 4'b0010) pre_seen <= 1'b1;
            if (pins == 4'b0001 && ref_seen != 2'd3) ref_seen <= ref_seen + 2'd1;
            if (!pre_seen && settle_cnt < STABLE_CYC) settle_cnt <= settle_cnt + 1;
        end
    end

    p_settle_nop_r1: assert property (@(posedge clk) disable iff (rst)
        (!pre_seen && settle_cnt < STABLE_CYC) |-> (pins == 4'b0111));
    p_prechg_all_r2: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010) |-> (addr[10] && !pre_seen && settle_cnt == STABLE_CYC));
    p_ref_after_pre_r3: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0001) |-> pre_seen);
    p_ref_limit_r4: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0001) |-> (ref_seen < 2'd2));
    p_cmd_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        (pins != 4'b0111) |=> (pins == 4'b0111));
    p_load_after_refs_r5: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000) |-> (ref_seen == 2'd2 && ba == '0 && addr[ADDR_W-1:10] == '0));
    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
    p_ready_idle_r6: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pins == 4'b0111 && ref_seen == 2'd2));
    p_cke_high_r7: assert property (@(posedge clk) disable iff (rst)
        cke);
    p_err_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!ready && pins != 4'b0000));
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .STABLE_CYC(CLK_MHZ * STABLE_US)
) chk_i (
    .clk(clk),
    .rst(rst),
    .cke(cke),
    .cs_n(cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n(we_n),
    .ba(ba),
    .addr(addr),
    .ready(ready),
    .cfg_err(cfg_err)
);

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S          = 100;   // CLK_MHZ=1 * STABLE_US=100
    // main instance spacings: tRP=3, tRFC=4, tMRD=2 -> gaps 2, 3, 1
    localparam int M_PRE  = S;
    localparam int M_REF1 = M_PRE + 2 + 1;
    localparam int M_REF2 = M_REF1 + 3 + 1;
    localparam int M_LMR  = M_REF2 + 3 + 1;
    localparam int M_RDY  = M_LMR + 1 + 1;
    localparam int M_WORD = (1 << 9) | (3 << 4) | (1 << 3) | 3;
    // sweep instances: all spacings 1 -> every gap clamps to 1
    localparam int A_LMR  = S + 6;
    localparam int A_RDY  = S + 8;
    localparam int NCFG   = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   n_checks = 0;
    int   n_err    = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic        m_cke, m_cs, m_ras, m_cas, m_we, m_rdy, m_err;
    logic [1:0]  m_ba;
    logic [12:0] m_addr;

    sdram_pwrup_seq #(
        .CLK_MHZ(1), .STABLE_US(100), .T_RP_CYC(3), .T_RFC_CYC(4), .T_MRD_CYC(2),
        .BL_CODE(3'd3), .BURST_INTERLEAVED(1'b1), .CL_CODE(3'd3), .WRITE_SINGLE(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .cke(m_cke), .cs_n(m_cs), .ras_n(m_ras), .cas_n(m_cas),
        .we_n(m_we), .ba(m_ba), .addr(m_addr), .ready(m_rdy), .cfg_err(m_err)
    );

    logic [NCFG-1:0][3:0]  a_cmd;
    logic [NCFG-1:0][12:0] a_addr;
    logic [NCFG-1:0]       a_rdy;
    logic [NCFG-1:0]       a_err;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam logic [2:0] BL = 3'(g % 8);
        localparam logic       BT = 1'((g / 8) % 2);
        localparam logic [2:0] CL = 3'((g / 16) % 8);
        localparam logic       WB = 1'((g / 2) % 2);
        logic        c_cke, c_cs, c_ras, c_cas, c_we, c_rdy, c_err;
        logic [1:0]  c_ba;
        logic [12:0] c_addr;
        sdram_pwrup_seq #(
            .CLK_MHZ(1), .STABLE_US(100), .T_RP_CYC(1), .T_RFC_CYC(1), .T_MRD_CYC(1),
            .BL_CODE(BL), .BURST_INTERLEAVED(BT), .CL_CODE(CL), .WRITE_SINGLE(WB)
        ) cfg_i (
            .clk(clk), .rst(rst), .cke(c_cke), .cs_n(c_cs), .ras_n(c_ras), .cas_n(c_cas),
            .we_n(c_we), .ba(c_ba), .addr(c_addr), .ready(c_rdy), .cfg_err(c_err)
        );
        assign a_cmd[g]  = {c_cs, c_ras, c_cas, c_we};
        assign a_addr[g] = c_addr;
        assign a_rdy[g]  = c_rdy;
        assign a_err[g]  = c_err;
    end

    task automatic chk(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic bit cfg_valid(input int i);
        int bl, bt, cl;
        bl = i % 8; bt = (i / 8) % 2; cl = (i / 16) % 8;
        return (cl == 2 || cl == 3) && (bl <= 3 || (bl == 7 && bt == 0));
    endfunction

    function automatic int cfg_word(input int i);
        return (((i / 2) % 2) << 9) | (((i / 16) % 8) << 4) | (((i / 8) % 2) << 3) | (i % 8);
    endfunction

    function automatic int main_cmd(input int j);
        if (j == M_PRE) return 4'b0010;
        if (j == M_REF1 || j == M_REF2) return 4'b0001;
        if (j == M_LMR) return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic string main_req(input int j);
        if (j < M_PRE) return "R1";
        if (j == M_PRE) return "R2";
        if (j <= M_REF1) return "R3";
        if (j < M_LMR) return "R4";
        if (j == M_LMR) return "R5";
        return "R6";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // reset state, sampled while rst is still high (R1, R6, R7, R8)
        chk("R1 nop in reset", {m_cs, m_ras, m_cas, m_we}, 4'b0111);
        chk("R6 ready in reset", m_rdy, 0);
        chk("R7 cke in reset", m_cke, 1);
        chk("R8 err in reset", m_err, 0);
        rst = 1'b0;
        for (int j = 0; j <= M_RDY + 6; j++) begin
            if (j > 0) @(negedge clk);
            chk($sformatf("%s cmd j=%0d", main_req(j), j), {m_cs, m_ras, m_cas, m_we}, main_cmd(j));
            chk($sformatf("R7 cke j=%0d", j), m_cke, 1);
            chk($sformatf("R6 ready j=%0d", j), m_rdy, (j >= M_RDY) ? 1 : 0);
            if (j == M_PRE)
                chk("R2 precharge-all addr", m_addr, 1 << 10);
            else if (j == M_LMR)
                chk("R5 mode word", m_addr, M_WORD);
            else if (j == 5 || j == M_REF1 || j == M_RDY)
                chk($sformatf("%s idle addr j=%0d", main_req(j), j), m_addr, 0);
            if (j == M_PRE || j == M_LMR)
                chk($sformatf("%s bank j=%0d", main_req(j), j), m_ba, 0);
            if (j == 1 || j == M_RDY)
                chk($sformatf("R8 legal word err j=%0d", j), m_err, 0);
            if (j == 0) begin
                for (int i = 0; i < NCFG; i++) begin
                    chk($sformatf("R8 err cleared cfg=%0d", i), a_err[i], 0);
                end
            end
            if (j == 1) begin
                for (int i = 0; i < NCFG; i++) begin
                    chk($sformatf("R8 err flag cfg=%0d", i), a_err[i], cfg_valid(i) ? 0 : 1);
                end
            end
            if (j == A_LMR - 4) begin
                for (int i = 0; i < NCFG; i++) begin
                    chk($sformatf("R4 clamped refresh cfg=%0d", i), a_cmd[i], 4'b0001);
                end
            end
            if (j == A_LMR) begin
                for (int i = 0; i < NCFG; i++) begin
                    if (cfg_valid(i)) begin
                        chk($sformatf("R5 load cmd cfg=%0d", i), a_cmd[i], 4'b0000);
                        chk($sformatf("R5 load word cfg=%0d", i), a_addr[i], cfg_word(i));
                    end else begin
                        chk($sformatf("R8 no load cfg=%0d", i), a_cmd[i], 4'b0111);
                    end
                end
            end
            if (j == A_RDY - 1) begin
                for (int i = 0; i < NCFG; i++) begin
                    chk($sformatf("R6 not yet ready cfg=%0d", i), a_rdy[i], 0);
                end
            end
            if (j == A_RDY + 1) begin
                for (int i = 0; i < NCFG; i++) begin
                    chk($sformatf("R6 ready cfg=%0d", i), a_rdy[i], cfg_valid(i) ? 1 : 0);
                    chk($sformatf("R8 halted nop cfg=%0d", i), a_cmd[i], 4'b0111);
                end
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule